// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block maps four level-sensitive PCI interrupt lines (A, B, C, D) onto sixteen legacy interrupt-controller request lines. Each PCI line owns a byte-wide routing register. Software loads these registers through a one-cycle write port. The low seven bits of a register name the target legacy IRQ. Bit 7 disables the line.

Several PCI lines may name the same legacy IRQ. Each legacy output is the OR of every enabled, validly routed PCI line that selects it. Some targets are reserved for system devices: IRQ 0, 1, 2, 8 and 13. A register that names a reserved target, or any value of 16 or above, leaves its line unrouted. All outputs are registered. Both a routing write and an input change show on the outputs after exactly one clock edge.

A parameter selects the reset contents of the routing registers:
- Mode 0 sends A and B to IRQ 10, and C and D to IRQ 11.
- Mode 1 loads 0x80 into every register, so every line starts disabled.

Top module: `pci_irq_router`

## Requirements
- R1: With reset mode 0, after reset lines A and B drive legacy IRQ 10 and lines C and D drive legacy IRQ 11.
- R2: With reset mode 1, after reset every routing register holds 0x80 and no PCI line drives any legacy output.
- R3: A write with `rt_wr_en` high stores `rt_wr_data` in the routing register of the line given by `rt_wr_sel` (0=A, 1=B, 2=C, 3=D) and leaves the other lines' routing unchanged.
- R4: Each legacy output bit n is the OR of the levels of all enabled PCI lines whose routing register bits 6:0 equal n; several lines may share one output.
- R5: A line whose routing register has bit 7 set contributes to no legacy output.
- R6: A routing register naming IRQ 0, 1, 2, 8 or 13 leaves its line unrouted; those legacy outputs never assert.
- R7: A routing register whose bits 6:0 hold a value of 16 or above leaves its line unrouted.
- R8: A change of a PCI input level, or a routing write, appears on `legacy_irq` at the first rising clock edge that samples it. When a line is retargeted, the old output drops the line and the new one picks it up at that same edge.
- R9: While `rst` is high at a rising edge, all legacy outputs are low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_wr_en | input | 1 | Routing register write strobe |
| rt_wr_sel | input | 2 | Index of the PCI line whose register is written |
| rt_wr_data | input | 8 | Routing value: bit 7 disable, bits 6:0 target IRQ |
| pci_int | input | 4 | PCI interrupt levels, bit 0 = line A |
| legacy_irq | output | 16 | Registered legacy IRQ request levels |

## Verification
The hardest case is a retarget while the line is active. The old and new outputs must swap at a single edge, with no cycle where both are high or both are low. The stimulus holds line A high on one target, then issues the rewrite. The sample taken just after the next edge must show only the new bit. Shared targets are reached by aiming two lines at one IRQ and releasing them one at a time. This shows that the output stays up until the last contributor drops.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    typedef logic [7:0] route_t;

    localparam int ROUTE_DIS_BIT = 7;
    // Legacy targets reserved for system devices: 0, 1, 2, 8, 13
    localparam logic [15:0] RESERVED_IRQ_MASK = 16'h2107;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int RESET_MODE = 0,
    localparam int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  route_t                   wr_data,
    output route_t [NUM_LINES-1:0]   route_q,
    output route_t [NUM_LINES-1:0]   route_d
);
    typedef struct packed {
        route_t [NUM_LINES-1:0] route;
    } regs_t;

    regs_t st_d, st_q;
    route_t [NUM_LINES-1:0] rst_val;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_rst
            if (RESET_MODE == 0) begin : g_mode0
                assign rst_val[g] = (g < 2) ? 8'h0A : 8'h0B;
            end else begin : g_mode1
                assign rst_val[g] = 8'h80;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.route = rst_val;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (wr_sel == SEL_W'(i)) st_d.route[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign route_q = st_q.route;
    assign route_d = st_d.route;

    // R3
    wr_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> route_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/pirq_decode.sv
module pirq_decode
    import pirq_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter logic [NUM_IRQ-1:0] EXCL_MASK = RESERVED_IRQ_MASK,
    localparam int IRQ_W = $clog2(NUM_IRQ)
) (
    input  route_t               route,
    output logic [NUM_IRQ-1:0]   sel
);
    logic          in_range;
    logic          enabled;
    logic [IRQ_W-1:0] target;

    always_comb begin
        target   = route[IRQ_W-1:0];
        in_range = ({1'b0, route[6:0]} < 8'(NUM_IRQ));
        enabled  = !route[ROUTE_DIS_BIT];
        sel      = '0;
        if (enabled && in_range && !EXCL_MASK[target]) begin
            sel[target] = 1'b1;
        end
    end
endmodule

// File: rtl/pirq_combine.sv
module pirq_combine #(
    parameter int NUM_LINES = 4,
    parameter int NUM_IRQ   = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_LINES-1:0]                line_lvl,
    input  logic [NUM_LINES-1:0][NUM_IRQ-1:0]   line_sel,
    output logic [NUM_IRQ-1:0]                  irq_q
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] irq;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.irq = '0;
        if (!rst) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (line_lvl[i]) o_d.irq = o_d.irq | line_sel[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    assign irq_q = o_q.irq;

    // R4
    quiet_inputs_chk: assert property (@(posedge clk) disable iff (rst)
        (line_lvl == '0) |=> (irq_q == '0));

    // R4
    fanout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(irq_q) <= $countones($past(line_lvl))));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pirq_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int NUM_IRQ    = 16,
    parameter int RESET_MODE = 0,
    localparam int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rt_wr_en,
    input  logic [SEL_W-1:0]      rt_wr_sel,
    input  logic [7:0]            rt_wr_data,
    input  logic [NUM_LINES-1:0]  pci_int,
    output logic [NUM_IRQ-1:0]    legacy_irq
);
    route_t [NUM_LINES-1:0]             route_q;
    route_t [NUM_LINES-1:0]             route_d;
    logic   [NUM_LINES-1:0][NUM_IRQ-1:0] line_sel;

    pirq_route_regs #(
        .NUM_LINES  (NUM_LINES),
        .RESET_MODE (RESET_MODE)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rt_wr_en),
        .wr_sel  (rt_wr_sel),
        .wr_data (rt_wr_data),
        .route_q (route_q),
        .route_d (route_d)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_dec
            pirq_decode #(
                .NUM_IRQ   (NUM_IRQ),
                .EXCL_MASK (NUM_IRQ'(RESERVED_IRQ_MASK))
            ) i_dec (
                .route (route_d[g]),
                .sel   (line_sel[g])
            );
        end
    endgenerate

    pirq_combine #(
        .NUM_LINES (NUM_LINES),
        .NUM_IRQ   (NUM_IRQ)
    ) i_comb (
        .clk      (clk),
        .rst      (rst),
        .line_lvl (pci_int),
        .line_sel (line_sel),
        .irq_q    (legacy_irq)
    );

    // R6
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((legacy_irq & NUM_IRQ'(RESERVED_IRQ_MASK)) == '0));

    // R5
    disabled_line_chk: assert property (@(posedge clk) disable iff (rst)
        (route_q[0][ROUTE_DIS_BIT] && !rt_wr_en && pci_int == 4'b0001)
        |=> (legacy_irq == '0));

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_sel[0]) && $onehot0(line_sel[NUM_LINES-1]));
endmodule

// File: tb/test_pci_irq_router.sv
`timescale 1ns/100ps
module test_pci_irq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rt_wr_en = 1'b0;
    logic [1:0]  rt_wr_sel = '0;
    logic [7:0]  rt_wr_data = '0;
    logic [3:0]  pci_int = '0;
    logic [15:0] legacy_irq;
    logic [15:0] legacy_irq_dis;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pci_irq_router #(.RESET_MODE(0)) i_pci_irq_router (
        .clk(clk), .rst(rst), .rt_wr_en(rt_wr_en), .rt_wr_sel(rt_wr_sel),
        .rt_wr_data(rt_wr_data), .pci_int(pci_int), .legacy_irq(legacy_irq));

    pci_irq_router #(.RESET_MODE(1)) i_pci_irq_router_dis (
        .clk(clk), .rst(rst), .rt_wr_en(1'b0), .rt_wr_sel(2'd0),
        .rt_wr_data(8'h00), .pci_int(pci_int), .legacy_irq(legacy_irq_dis));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs before an edge, then sample just after it.
    task automatic cyc(input logic [3:0] p, input bit we, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        pci_int    = p;
        rt_wr_en   = we;
        rt_wr_sel  = sel;
        rt_wr_data = d;
        @(posedge clk);
        #1;
        rt_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        pci_int = 4'b1111;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R9 reset outputs low", legacy_irq, 16'h0000);
        check("R9 reset outputs low (mode 1)", legacy_irq_dis, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        pci_int = 4'b0000;
        @(posedge clk); #1;
        check("R9 idle after reset", legacy_irq, 16'h0000);
    endtask

    task automatic t_defaults();
        cyc(4'b0001, 0, 0, 0); check("R1 A->10", legacy_irq, 16'h0400);
        cyc(4'b0010, 0, 0, 0); check("R1 B->10", legacy_irq, 16'h0400);
        cyc(4'b0100, 0, 0, 0); check("R1 C->11", legacy_irq, 16'h0800);
        cyc(4'b1000, 0, 0, 0); check("R1 D->11", legacy_irq, 16'h0800);
        cyc(4'b1111, 0, 0, 0); check("R1 all", legacy_irq, 16'h0C00);
        check("R2 mode 1 all disabled", legacy_irq_dis, 16'h0000);
        cyc(4'b0000, 0, 0, 0);
    endtask

    task automatic t_sharing();
        cyc(4'b0000, 1, 0, 8'h05);
        cyc(4'b0000, 1, 1, 8'h05);
        cyc(4'b0000, 1, 2, 8'h09);
        cyc(4'b0000, 1, 3, 8'h09);
        cyc(4'b0001, 0, 0, 0); check("R4 A alone on 5", legacy_irq, 16'h0020);
        cyc(4'b0011, 0, 0, 0); check("R4 A|B share 5", legacy_irq, 16'h0020);
        cyc(4'b0010, 0, 0, 0); check("R4 B keeps 5 up", legacy_irq, 16'h0020);
        cyc(4'b1110, 0, 0, 0); check("R4 5 and 9", legacy_irq, 16'h0220);
        cyc(4'b0000, 0, 0, 0); check("R4 all released", legacy_irq, 16'h0000);
    endtask

    task automatic t_write_index();
        cyc(4'b0000, 1, 2, 8'h07);
        cyc(4'b1111, 0, 0, 0); check("R3 only C moved to 7", legacy_irq, 16'h02A0);
        cyc(4'b0000, 0, 0, 0);
    endtask

    task automatic t_disable();
        cyc(4'b0000, 1, 0, 8'h85);
        cyc(4'b0001, 0, 0, 0); check("R5 disabled A silent", legacy_irq, 16'h0000);
        cyc(4'b0011, 0, 0, 0); check("R5 B still on 5", legacy_irq, 16'h0020);
        cyc(4'b0000, 0, 0, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] rsv [5] = '{8'd0, 8'd1, 8'd2, 8'd8, 8'd13};
        for (int k = 0; k < 5; k++) begin
            cyc(4'b0000, 1, 0, rsv[k]);
            cyc(4'b0001, 0, 0, 0);
            check($sformatf("R6 reserved IRQ %0d", rsv[k]), legacy_irq, 16'h0000);
            cyc(4'b0000, 0, 0, 0);
        end
    endtask

    task automatic t_range();
        cyc(4'b0000, 1, 0, 8'h1A);
        cyc(4'b0001, 0, 0, 0); check("R7 target 26 unrouted", legacy_irq, 16'h0000);
        cyc(4'b0000, 1, 0, 8'h7F);
        cyc(4'b0001, 0, 0, 0); check("R7 target 127 unrouted", legacy_irq, 16'h0000);
        cyc(4'b0000, 1, 0, 8'h13);
        cyc(4'b0001, 0, 0, 0); check("R7 target 19 unrouted", legacy_irq, 16'h0000);
        cyc(4'b0000, 0, 0, 0);
    endtask

    task automatic t_timing();
        cyc(4'b0000, 1, 0, 8'h06);
        cyc(4'b0001, 0, 0, 0); check("R8 rise after one edge", legacy_irq, 16'h0040);
        cyc(4'b0001, 1, 0, 8'h0C); check("R8 retarget swap", legacy_irq, 16'h1000);
        cyc(4'b0001, 0, 0, 0); check("R8 retarget holds", legacy_irq, 16'h1000);
        cyc(4'b0000, 0, 0, 0); check("R8 fall after one edge", legacy_irq, 16'h0000);
        cyc(4'b0001, 1, 0, 8'h8C); check("R8 disable takes effect at once", legacy_irq, 16'h0000);
        cyc(4'b0000, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_sharing();
        t_write_index();
        t_disable();
        t_reserved();
        t_range();
        t_timing();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule